// File: doc/BRIEF.md
# Clocked Chip-Enable ROM Read Sequencer

This block sits on the host side of an 8K x 8 read-only memory whose chip-enable is edge-sensitive. The memory latches its address when chip-enable falls. It needs a minimum and maximum low pulse, and it must see chip-enable high for a recovery interval between accesses. A client hands the sequencer a 13-bit address on a valid/ready handshake. The sequencer drives the address and the active-low chip-enable and output-enable strobes. It waits out the access time, samples the byte and returns it as a single-cycle response pulse.

Two speed grades are supported through one parameter. Every nanosecond figure is turned into clock cycles by rounding up. After reset the memory is kept deselected for a power-up interval before the first request is taken. Once the address hold time of the current access has elapsed, the sequencer can take one further request. It drives the new address at once, so the next access starts as soon as the recovery interval ends, with no separate setup cycle.

With the defaults (200 MHz clock, faster grade), the counts are: 12 cycles of hold, a 50-cycle low phase and 25 cycles of recovery, which gives a 75-cycle access period.

Top module: `memrd_seq`

## Requirements
- R1: While reset is asserted, chip-enable and output-enable are high, req_ready is low and rsp_valid is low.
- R2: After reset is released, chip-enable stays high and req_ready stays low for the power-up count plus two synchroniser cycles. This is 202 cycles with a 1000 ns power-up setting. A request held valid during that time is not started.
- R3: The address on mem_addr is stable for at least one cycle before chip-enable falls.
- R4: mem_addr does not change during the first 12 cycles (hold count) of a low chip-enable phase.
- R5: Output-enable is low exactly in the cycles where chip-enable is low.
- R6: Every chip-enable low phase lasts exactly 50 cycles (60 on the slower grade), which is at most 10,000 ns. The byte is sampled at the clock edge that ends the phase.
- R7: rsp_valid is a one-cycle pulse carrying the byte stored at the requested address. For a request accepted while idle, it arrives 51 cycles after the accepting edge.
- R8: Chip-enable stays high for at least 25 cycles (30 on the slower grade) between two low phases. The full access period is never shorter than 75 cycles (90).
- R9: req_ready is high when idle. It is low during power-up and during the first 12 cycles of a low phase. It is also low while one accepted request is still waiting to start.
- R10: A request accepted during an access has its address driven at acceptance. Its low phase begins directly at the end of recovery, so back-to-back responses are exactly 75 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 13 | Byte address to read |
| rsp_valid | output | 1 | One-cycle pulse: rsp_data holds a read byte |
| rsp_data | output | 8 | Byte read from the memory |
| mem_addr | output | 13 | Address to the memory |
| mem_ce_n | output | 1 | Active-low chip-enable to the memory |
| mem_oe_n | output | 1 | Active-low output-enable to the memory |
| mem_data | input | 8 | Data bus from the memory |

## Verification
The bench counts clock edges from reset release and from each accepting edge, and samples on the falling edge.

- req_ready must rise 202 edges after reset release.
- A response to an idle request must appear 51 edges after acceptance.
- Overlapped requests must answer in exactly 75-edge steps.

A memory model latches the address at the falling chip-enable. It drives real data only once 50 low cycles and 16 output-enable cycles have passed, and 0xEE before that. An early sample therefore shows up as a data mismatch. A monitor measures every low and high phase and every address change against the hold window.

// File: rtl/memrd_pkg.sv
package memrd_pkg;

  typedef enum logic [2:0] {
    ST_POWERUP,
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_CAPTURE,
    ST_PRECHARGE
  } memrd_state_e;

  // nanoseconds to clock cycles, rounding up
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/memrd_rst_sync.sv
module memrd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/memrd_fsm.sv
module memrd_fsm
  import memrd_pkg::*;
#(
  parameter int unsigned N_PWR  = 400000,
  parameter int unsigned N_LOW  = 50,
  parameter int unsigned N_PRE  = 25,
  parameter int unsigned T_HOLD = 12,
  parameter int unsigned CW     = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic load_addr,
  output logic capture,
  output logic mem_ce_n,
  output logic mem_oe_n
);
  localparam logic [CW-1:0] PWR_LAST = CW'(N_PWR - 1);
  localparam logic [CW-1:0] LOW_LAST = CW'(N_LOW - 1);
  localparam logic [CW-1:0] PRE_LAST = CW'(N_PRE - 2);
  localparam logic [CW-1:0] HOLD_C   = CW'(T_HOLD);

  memrd_state_e  state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          ce_n_q, ce_n_d;
  logic          oe_n_q;
  logic          accept;

  // handshake
  always_comb begin
    unique case (state_q)
      ST_IDLE:                  req_ready = 1'b1;
      ST_ACCESS:                req_ready = !pend_q && (cnt_q >= HOLD_C);
      ST_CAPTURE, ST_PRECHARGE: req_ready = !pend_q;
      default:                  req_ready = 1'b0;
    endcase
  end

  assign accept    = req_valid && req_ready;
  assign load_addr = accept;

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    pend_d  = pend_q;
    capture = 1'b0;
    if (accept && (state_q != ST_IDLE)) pend_d = 1'b1;
    unique case (state_q)
      ST_POWERUP: begin
        if (cnt_q == PWR_LAST) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      end
      ST_IDLE: begin
        cnt_d = '0;
        if (accept) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        state_d = ST_ACCESS;
        cnt_d   = '0;
      end
      ST_ACCESS: begin
        if (cnt_q == LOW_LAST) begin
          state_d = ST_CAPTURE;
          capture = 1'b1;
          cnt_d   = '0;
        end
      end
      ST_CAPTURE: begin
        state_d = ST_PRECHARGE;
        cnt_d   = '0;
      end
      ST_PRECHARGE: begin
        if (cnt_q == PRE_LAST) begin
          cnt_d  = '0;
          pend_d = 1'b0;
          if (pend_q)      state_d = ST_ACCESS;
          else if (accept) state_d = ST_SETUP;
          else             state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_POWERUP;
        cnt_d   = '0;
      end
    endcase
    ce_n_d = (state_d != ST_ACCESS);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POWERUP;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      ce_n_q  <= ce_n_d;
      oe_n_q  <= ce_n_d;
    end
  end

  assign mem_ce_n = ce_n_q;
  assign mem_oe_n = oe_n_q;

  assert_pwr_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POWERUP) |-> (!req_ready && mem_ce_n));

  assert_oe_with_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n) |-> (!mem_ce_n));

  assert_pend_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !req_ready);

  assert_start_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (($past(state_q) == ST_SETUP) || $past(pend_q)));
endmodule

// File: rtl/memrd_dpath.sv
module memrd_dpath #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (load_addr) addr_q <= req_addr;
      if (capture)   data_q <= mem_data;
      valid_q <= capture;
    end
  end

  assign mem_addr  = addr_q;
  assign rsp_valid = valid_q;
  assign rsp_data  = data_q;

  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
endmodule

// File: rtl/memrd_seq.sv
module memrd_seq
  import memrd_pkg::*;
#(
  parameter int unsigned CLK_NS     = 5,
  parameter bit          FAST_GRADE = 1'b1,
  parameter int unsigned PWRUP_NS   = 2000000,
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_data
);
  localparam int unsigned T_ACC   = ns_to_cyc(FAST_GRADE ? 250 : 300, CLK_NS);
  localparam int unsigned T_PWMIN = ns_to_cyc(FAST_GRADE ? 250 : 300, CLK_NS);
  localparam int unsigned T_PWMAX = ns_to_cyc(10000, CLK_NS);
  localparam int unsigned T_HOLD  = ns_to_cyc(FAST_GRADE ? 60 : 75, CLK_NS);
  localparam int unsigned T_OEA   = ns_to_cyc(FAST_GRADE ? 80 : 100, CLK_NS);
  localparam int unsigned T_PRE   = ns_to_cyc(FAST_GRADE ? 125 : 150, CLK_NS);
  localparam int unsigned T_CYC   = ns_to_cyc(FAST_GRADE ? 375 : 450, CLK_NS);
  localparam int unsigned N_PWR   = umax(ns_to_cyc(PWRUP_NS, CLK_NS), 1);
  localparam int unsigned N_LOW   = umax(umax(T_ACC, T_PWMIN), T_OEA);
  localparam int unsigned N_PRE   = umax(umax(T_PRE, (T_CYC > N_LOW) ? T_CYC - N_LOW : 0), 2);
  localparam int unsigned CW      = $clog2(umax(umax(N_PWR, N_LOW), N_PRE) + 1);
  localparam int unsigned LW      = $clog2(T_PWMAX + 2);
  localparam int unsigned HW      = $clog2(N_PRE + 1);

  logic rst_n_s;
  logic load_addr, capture;

  memrd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  memrd_fsm #(
    .N_PWR  (N_PWR),
    .N_LOW  (N_LOW),
    .N_PRE  (N_PRE),
    .T_HOLD (T_HOLD),
    .CW     (CW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .load_addr (load_addr),
    .capture   (capture),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n)
  );

  memrd_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load_addr (load_addr),
    .req_addr  (req_addr),
    .capture   (capture),
    .mem_data  (mem_data),
    .mem_addr  (mem_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // phase-length counters watched by the timing assertions
  logic [LW-1:0] lo_cnt_q;
  logic [HW-1:0] hi_cnt_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      lo_cnt_q <= '0;
      hi_cnt_q <= '0;
    end else begin
      if (!mem_ce_n) begin
        if (lo_cnt_q != LW'(T_PWMAX + 1)) lo_cnt_q <= lo_cnt_q + 1'b1;
      end else begin
        lo_cnt_q <= '0;
      end
      if (mem_ce_n) begin
        if (hi_cnt_q != HW'(N_PRE)) hi_cnt_q <= hi_cnt_q + 1'b1;
      end else begin
        hi_cnt_q <= '0;
      end
    end
  end

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!mem_ce_n && (lo_cnt_q < LW'(T_HOLD))) |=> $stable(mem_addr));

  assert_low_width_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(mem_ce_n) |-> ((lo_cnt_q == LW'(N_LOW)) && (lo_cnt_q <= LW'(T_PWMAX))));

  assert_high_width_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(mem_ce_n) |-> (hi_cnt_q >= HW'(N_PRE)));
endmodule

// File: tb/memrd_seq_tb.sv
`timescale 1ns/1ps
module memrd_seq_tb;
  localparam int T_HOLD = 12;
  localparam int N_LOW  = 50;
  localparam int N_PRE  = 25;
  localparam int N_OEA  = 16;
  localparam int PWR_RDY = 202;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [12:0] req_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [12:0] mem_addr;
  logic        mem_ce_n;
  logic        mem_oe_n;
  logic [7:0]  mem_data = 8'hEE;

  always #2.5 clk = ~clk;

  memrd_seq #(.CLK_NS(5), .FAST_GRADE(1'b1), .PWRUP_NS(1000)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_data(mem_data)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  int          acc_at[16];
  int          rsp_at[16];
  logic [7:0]  exp_d[16];
  int          n_sent = 0;
  int          n_rsp = 0;

  always @(posedge clk) cyc++;

  function automatic logic [7:0] rom_byte(input logic [12:0] a);
    return {a[12:8], 3'b000} ^ a[7:0] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // memory model and bus monitor
  bit          prev_ce = 1'b1;
  logic [12:0] prev_addr = '0;
  logic [12:0] fall_addr = '0;
  int          lo_n = 0;
  int          oe_lo = 0;
  int          hi_n = 0;
  bit          seen_low = 1'b0;
  bit          hold_bad = 1'b0;
  bit          oe_bad = 1'b0;
  bit          prev_rsp = 1'b0;

  always @(negedge clk) begin
    if (mem_oe_n != mem_ce_n) oe_bad = 1'b1;
    if (!mem_ce_n) begin
      if (prev_ce) begin
        check(mem_addr == prev_addr, "R3", "address stable before ce fall", int'(mem_addr), int'(prev_addr));
        if (seen_low) check(hi_n >= N_PRE, "R8", "ce high cycles", hi_n, N_PRE);
        fall_addr = mem_addr;
        lo_n = 0;
        oe_lo = 0;
        hold_bad = 1'b0;
      end
      lo_n++;
      if (!mem_oe_n) oe_lo++;
      if (mem_addr != fall_addr && lo_n <= T_HOLD) hold_bad = 1'b1;
      mem_data = (lo_n >= N_LOW && oe_lo >= N_OEA) ? rom_byte(fall_addr) : 8'hEE;
    end else begin
      if (!prev_ce) begin
        check(lo_n == N_LOW, "R6", "ce low cycles", lo_n, N_LOW);
        check(!hold_bad, "R4", "address changed inside hold window", int'(hold_bad), 0);
        check(!oe_bad, "R5", "oe differs from ce", int'(oe_bad), 0);
        oe_bad = 1'b0;
        seen_low = 1'b1;
        hi_n = 0;
      end
      hi_n++;
      mem_data = 8'hEE;
    end
    if (rsp_valid) begin
      check(!prev_rsp, "R7", "rsp_valid longer than one cycle", 1, 0);
      if (n_rsp < 16) begin
        rsp_at[n_rsp] = cyc;
        check(rsp_data == exp_d[n_rsp], "R7", "response byte", int'(rsp_data), int'(exp_d[n_rsp]));
      end
      n_rsp++;
    end
    prev_rsp = rsp_valid;
    prev_ce = mem_ce_n;
    prev_addr = mem_addr;
  end

  task automatic send(input logic [12:0] a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = a;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    acc_at[n_sent] = cyc;
    exp_d[n_sent] = rom_byte(a);
    n_sent++;
  endtask

  task automatic wait_rsp(input int n);
    for (int i = 0; i < 400 && n_rsp < n; i++) @(negedge clk);
    check(n_rsp >= n, "R7", "responses received", n_rsp, n);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(mem_ce_n === 1'b1, "R1", "ce_n in reset", int'(mem_ce_n), 1);
    check(mem_oe_n === 1'b1, "R1", "oe_n in reset", int'(mem_oe_n), 1);
    check(req_ready === 1'b0, "R1", "ready in reset", int'(req_ready), 0);
    check(rsp_valid === 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
  endtask

  task automatic t_powerup();
    int c0;
    int bad;
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1;
    req_addr = 13'h0ABC;
    c0 = cyc;
    bad = 0;
    for (int i = 1; i < PWR_RDY; i++) begin
      @(negedge clk);
      if (req_ready || !mem_ce_n) bad++;
    end
    check(bad == 0, "R2", "cycles with ready or ce low during power-up", bad, 0);
    check(req_ready == 1'b0, "R2", "ready one cycle before end", int'(req_ready), 0);
    @(negedge clk);
    check(req_ready == 1'b1 && (cyc - c0) == PWR_RDY, "R2", "ready at end of power-up", cyc - c0, PWR_RDY);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    acc_at[n_sent] = cyc;
    exp_d[n_sent] = rom_byte(13'h0ABC);
    n_sent++;
    wait_rsp(1);
    check(rsp_at[0] - acc_at[0] == 51, "R7", "latency of first read", rsp_at[0] - acc_at[0], 51);
  endtask

  task automatic t_single(input logic [12:0] a);
    int idx;
    idx = n_sent;
    repeat (30) @(negedge clk);
    check(req_ready == 1'b1, "R9", "ready while idle", int'(req_ready), 1);
    send(a);
    repeat (5) @(negedge clk);
    check(req_ready == 1'b0, "R9", "ready inside hold window", int'(req_ready), 0);
    wait_rsp(idx + 1);
    check(rsp_at[idx] - acc_at[idx] == 51, "R7", "latency from idle", rsp_at[idx] - acc_at[idx], 51);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R7", "rsp_valid after pulse", int'(rsp_valid), 0);
  endtask

  task automatic t_back2back();
    int i0;
    i0 = n_sent;
    repeat (30) @(negedge clk);
    send(13'h0123);
    send(13'h1E45);
    check(acc_at[i0+1] - acc_at[i0] > T_HOLD, "R9", "second accept after hold window",
          acc_at[i0+1] - acc_at[i0], T_HOLD + 1);
    check(req_ready == 1'b0, "R9", "ready with a request pending", int'(req_ready), 0);
    send(13'h0F0F);
    wait_rsp(i0 + 3);
    check(rsp_at[i0+1] - rsp_at[i0] == 75, "R10", "spacing of overlapped responses",
          rsp_at[i0+1] - rsp_at[i0], 75);
    check(rsp_at[i0+2] - rsp_at[i0+1] == 75, "R8", "full access period",
          rsp_at[i0+2] - rsp_at[i0+1], 75);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_single(13'h1F00);
    t_single(13'h1FFF);
    t_single(13'h0000);
    t_back2back();
    repeat (40) @(negedge clk);
    check(n_rsp == n_sent, "R7", "one response per request", n_rsp, n_sent);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end
endmodule